// File: doc/BRIEF.md
# Cascaded 128-Source Interrupt Router

The router gathers 128 level-sensitive interrupt request lines and steers each of them to one of eight processor-side outputs. There are six general interrupt lines, one nonmaskable line and one debug line. Each source has a mask bit, and a set mask bit blocks that source. Each source also has a 3-bit route code that picks its destination output. Every output is the registered OR of all unblocked, active sources whose route code selects it.

Software reaches the block through a plain register port with valid, write, address and 64-bit data. Each 128-bit logical register (raw status, mask, masked status) appears as two 64-bit words. Sources 0..63 sit in the upper-index word, at the base offset. Sources 64..127 sit in the other word, placed 0x1000 higher, so address bit 12 picks the word. Source k lands on bit k mod 64 of its word. Bit 0 of the base-offset word is not a source. It reads as the OR of all 64 bits of the word at +0x1000 of the same register, so one read tells software whether the second word needs reading at all. The eight sources 56..63 form a mailbox group, and a single group register masks or unmasks all eight together.

Register map (byte addresses, all 8-byte aligned):

| Offset | Access | Content |
|---|---|---|
| 0x0000 / 0x1000 | read-only | raw status, sources 0..63 / 64..127 |
| 0x0008 / 0x1008 | read/write | mask, sources 0..63 / 64..127 (1 = blocked) |
| 0x0010 / 0x1010 | read-only | masked status (raw AND NOT mask) |
| 0x0018 | read/write | mailbox group: bit 0 write sets or clears all group mask bits, read gives AND of them |
| 0x0800 + 8*k | read/write | route code of source k in bits 2:0 |

Top module: `irq_router`

## Requirements
- R1: Raw status captures the sources on every clock. Source k (1..63) reads at bit k of word 0x0000, and source k (64..127) reads at bit k-64 of word 0x1000. Input src_i[0] is never captured and never reaches an output.
- R2: Address bit 12 selects the second word of each 128-bit register: 0x1000, 0x1008 and 0x1010 hold sources 64..127 of raw status, mask and masked status.
- R3: Bit 0 of words 0x0000, 0x0008 and 0x0010 reads as the OR of all bits of the word 0x1000 above it.
- R4: A set mask bit blocks its source. Masked status equals raw status AND NOT mask. A mask write stores bits 63:1 (word 0x0008) or bits 63:0 (word 0x1008).
- R5: Route code c in 0..5 drives gen_irq_o[c], code 6 drives nmi_o and code 7 drives dbg_o. Each output is the OR of all unmasked active sources routed to it.
- R6: The route register of source k is at 0x0800 + 8*k. A write stores wdata bits 2:0, and a read returns the code with bits 63:3 zero.
- R7: Writing 0x0018 sets (wdata bit 0 = 1) or clears all mask bits of sources 56..63 at once and leaves other mask bits alone. Reading 0x0018 returns in bit 0 the AND of those eight mask bits, and zero above.
- R8: After reset every mask bit is 1, every route code is 0, all outputs are 0 and rdata_o is 0.
- R9: A read request sampled at clock edge n shows its data on rdata_o after edge n. A source level sampled at edge n appears in the status words after edge n and on its routed output after edge n+1.
- R10: A write to bit 0 of mask word 0x0008 is ignored. That bit always reads as the live OR of mask word 0x1008.
- R11: Reads of unmapped or misaligned addresses return zero. Writes to them, and writes to the read-only status words, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| src_i | input | NUM_SRC | level interrupt sources |
| req_i | input | 1 | register access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | byte address |
| wdata_i | input | DATA_W | write data |
| rdata_o | output | DATA_W | read data, valid after the request edge |
| gen_irq_o | output | 6 | general interrupt outputs (route codes 0..5) |
| nmi_o | output | 1 | nonmaskable output (route code 6) |
| dbg_o | output | 1 | debug output (route code 7) |

## Verification
The bench builds the router with 8-bit words (16 sources) and a 4-wide mailbox group at bits 4..7, keeping the default address map. At that size every source can be swept through all eight route codes, and the cascade bit is exercised for both empty and non-empty second words. Mask patterns and group writes can then be checked against a bench-side arithmetic model of masked status and of every output.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ROUTE_W = 3;
  localparam int unsigned OUT_N   = 1 << ROUTE_W;

  typedef logic [ROUTE_W-1:0] route_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_MASK,
    SEL_ACT,
    SEL_GRP,
    SEL_ROUTE
  } reg_sel_e;

  // destination line for a route code: code c -> output bit c
  function automatic logic [OUT_N-1:0] route_onehot(input route_t code);
    return OUT_N'(1) << code;
  endfunction
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned HALF_W     = 64,
  parameter int unsigned NUM_SRC    = 2 * HALF_W,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LOW_BIT    = 12,
  parameter int unsigned ROUTE_BASE = 'h800,
  parameter int unsigned GRP_LSB    = 56,
  parameter int unsigned GRP_W      = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              src_i,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_SRC-1:0]              act_o,
  output logic [NUM_SRC-1:0][ROUTE_W-1:0] route_o
);
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam int unsigned ROUTE_END = ROUTE_BASE + 8 * NUM_SRC;

  logic [NUM_SRC-1:0]              raw_q, mask_q;
  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_q;
  logic [DATA_W-1:0]               rdata_q, rd_d;
  logic [ADDR_W-1:0]               off;
  logic                            half;
  reg_sel_e                        sel;
  logic [IDX_W-1:0]                idx;

  // named events for the assertions
  logic wr_en, rd_en, wr_mask_hi, wr_mask_lo, wr_grp, wr_route, wr_ignored;

  // 128-bit register -> one 64-bit word; base word carries the cascade bit
  function automatic logic [DATA_W-1:0] casc_word(input logic [NUM_SRC-1:0] v,
                                                  input logic             second);
    if (second) return DATA_W'(v[NUM_SRC-1:HALF_W]);
    return DATA_W'({v[HALF_W-1:1], |v[NUM_SRC-1:HALF_W]});
  endfunction

  // address decode
  always_comb begin
    off          = addr_i;
    off[LOW_BIT] = 1'b0;
    half         = addr_i[LOW_BIT];
    sel          = SEL_NONE;
    idx          = '0;
    if (addr_i[2:0] == 3'b000) begin
      if (off == ADDR_W'(0))                     sel = SEL_RAW;
      else if (off == ADDR_W'(8))                sel = SEL_MASK;
      else if (off == ADDR_W'(16))               sel = SEL_ACT;
      else if (off == ADDR_W'(24) && !half)      sel = SEL_GRP;
      else if (!half && off >= ADDR_W'(ROUTE_BASE) && off < ADDR_W'(ROUTE_END)) begin
        sel = SEL_ROUTE;
        idx = IDX_W'((off - ADDR_W'(ROUTE_BASE)) >> 3);
      end
    end
  end

  assign wr_en      = req_i && we_i;
  assign rd_en      = req_i && !we_i;
  assign wr_mask_hi = wr_en && sel == SEL_MASK && !half;
  assign wr_mask_lo = wr_en && sel == SEL_MASK && half;
  assign wr_grp     = wr_en && sel == SEL_GRP;
  assign wr_route   = wr_en && sel == SEL_ROUTE;
  assign wr_ignored = wr_en && (sel == SEL_NONE || sel == SEL_RAW || sel == SEL_ACT);

  assign act_o   = raw_q & ~mask_q;
  assign route_o = route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      mask_q  <= '1;
      route_q <= '0;
    end else begin
      raw_q <= {src_i[NUM_SRC-1:1], 1'b0};
      if (wr_mask_hi) mask_q[HALF_W-1:1]        <= wdata_i[HALF_W-1:1];
      if (wr_mask_lo) mask_q[NUM_SRC-1:HALF_W]  <= wdata_i[HALF_W-1:0];
      if (wr_grp)     mask_q[GRP_LSB +: GRP_W]  <= {GRP_W{wdata_i[0]}};
      if (wr_route)   route_q[idx]              <= wdata_i[ROUTE_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_RAW:   rd_d = casc_word(raw_q, half);
      SEL_MASK:  rd_d = casc_word(mask_q, half);
      SEL_ACT:   rd_d = casc_word(act_o, half);
      SEL_GRP:   rd_d = DATA_W'(&mask_q[GRP_LSB +: GRP_W]);
      SEL_ROUTE: rd_d = DATA_W'(route_q[idx]);
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end
  assign rdata_o = rdata_q;

  p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_hi |=> mask_q[HALF_W-1:1] == $past(wdata_i[HALF_W-1:1]));
  p_group_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grp |=> mask_q[GRP_LSB +: GRP_W] == {GRP_W{$past(wdata_i[0])}});
  p_ignored_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> $stable(mask_q) && $stable(route_q));
  p_reset_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&mask_q) && (route_q == '0));
endmodule

// File: rtl/irq_router_fanin.sv
module irq_router_fanin
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              act_i,
  input  logic [NUM_SRC-1:0][ROUTE_W-1:0] route_i,
  output logic [OUT_N-1:0]                out_o
);
  logic [OUT_N-1:0] hit;
  logic [OUT_N-1:0] out_q;

  // one OR tree per destination
  for (genvar o = 0; o < OUT_N; o++) begin : g_out
    logic [NUM_SRC-1:0] pick;
    always_comb begin
      for (int k = 0; k < NUM_SRC; k++)
        pick[k] = act_i[k] && route_onehot(route_i[k])[o];
    end
    assign hit[o] = |pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= hit;
  end
  assign out_o = out_q;

  p_out_needs_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_q) |-> $past(|act_i));
  p_idle_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == '0) |=> (out_q == '0));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned HALF_W     = 64,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned LOW_BIT    = 12,
  parameter int unsigned ROUTE_BASE = 'h800,
  parameter int unsigned GRP_LSB    = 56,
  parameter int unsigned GRP_W      = 8,
  localparam int unsigned NUM_SRC   = 2 * HALF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [5:0]         gen_irq_o,
  output logic               nmi_o,
  output logic               dbg_o
);
  logic [NUM_SRC-1:0]              act;
  logic [NUM_SRC-1:0][ROUTE_W-1:0] route;
  logic [OUT_N-1:0]                outs;

  irq_router_regs #(
    .HALF_W(HALF_W), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LOW_BIT(LOW_BIT), .ROUTE_BASE(ROUTE_BASE), .GRP_LSB(GRP_LSB), .GRP_W(GRP_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .act_o(act), .route_o(route)
  );

  irq_router_fanin #(.NUM_SRC(NUM_SRC)) u_fanin (
    .clk(clk), .rst_n(rst_n), .act_i(act), .route_i(route), .out_o(outs)
  );

  assign gen_irq_o = outs[5:0];
  assign nmi_o     = outs[6];
  assign dbg_o     = outs[7];
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int HW = 8;
  localparam int NS = 2 * HW;
  localparam int AW = 16;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [5:0]    gen_irq;
  logic          nmi, dbg;

  always #5 clk = ~clk;

  irq_router #(.HALF_W(HW), .GRP_LSB(4), .GRP_W(4)) u_irq_router (
    .clk(clk), .rst_n(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .gen_irq_o(gen_irq), .nmi_o(nmi), .dbg_o(dbg)
  );

  int n_chk = 0, n_bad = 0;
  logic [NS-1:0] mask_sh;
  logic [2:0]    route_sh [NS];
  logic [DW-1:0] got;

  task automatic check(input string req_tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] w_base(input logic [NS-1:0] v);
    return DW'({v[HW-1:1], |v[NS-1:HW]});
  endfunction
  function automatic logic [DW-1:0] w_second(input logic [NS-1:0] v);
    return DW'(v[NS-1:HW]);
  endfunction
  function automatic logic [7:0] exp_out(input logic [NS-1:0] s);
    logic [7:0] r = '0;
    for (int k = 1; k < NS; k++)
      if (s[k] && !mask_sh[k]) r[route_sh[k]] = 1'b1;
    return r;
  endfunction
  function automatic logic [DW-1:0] outs();
    return DW'({dbg, nmi, gen_irq});
  endfunction

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask
  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata; req = 1'b0;
  endtask
  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NS-1:0] pats [5];
    logic [NS-1:0] mpats [4];
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; src = '0;
    mask_sh = '1;
    for (int k = 0; k < NS; k++) route_sh[k] = 3'd0;
    settle(3);
    check("R8 rdata after reset", rdata, '0);
    rst_n = 1'b1;
    settle(1);
    check("R8 outputs after reset", outs(), '0);
    bus_rd(16'h0008, got); check("R8 R3 mask base word after reset", got, 64'hFF);
    bus_rd(16'h1008, got); check("R8 R2 mask second word after reset", got, 64'hFF);
    bus_rd(16'h0828, got); check("R8 route code after reset", got, '0);

    // R1 R2 R3 raw status sweep
    pats = '{16'h0001, 16'h8000, 16'h00FE, 16'h0100, 16'hA55A};
    foreach (pats[i]) begin
      src = pats[i];
      settle(2);
      bus_rd(16'h0000, got); check("R1 R3 raw base word", got, w_base(pats[i] & 16'hFFFE));
      bus_rd(16'h1000, got); check("R1 R2 raw second word", got, w_second(pats[i]));
    end
    src = '0;

    // unmask everything; R10 cascade bit write ignored
    bus_wr(16'h1008, '0);
    bus_wr(16'h0008, 64'h01);
    mask_sh = 16'h0001;
    bus_rd(16'h0008, got); check("R10 cascade bit ignores write", got, 64'h00);
    bus_rd(16'h1008, got); check("R4 mask second word write", got, 64'h00);

    // R5 R6 exhaustive source x route sweep
    for (int k = 1; k < NS; k++) begin
      for (int c = 0; c < 8; c++) begin
        bus_wr(AW'(16'h0800 + 8 * k), {61'h1FFF_FFFF_FFFF_FFFF, 3'(c)});
        route_sh[k] = 3'(c);
        bus_rd(AW'(16'h0800 + 8 * k), got);
        check("R6 route readback", got, DW'(c));
        src = NS'(1) << k;
        settle(2);
        check("R5 routed output", outs(), DW'(8'(1) << c));
        src = '0;
        settle(2);
      end
    end

    // R9 latency on route code 2
    bus_wr(16'h0818, 64'h2); route_sh[3] = 3'd2;
    src = 16'h0008;
    settle(1); check("R9 output not yet after first edge", outs(), '0);
    settle(1); check("R9 output after second edge", outs(), 64'h04);
    src = '0;
    settle(1); check("R9 output holds one edge after drop", outs(), 64'h04);
    settle(1); check("R9 output clears", outs(), '0);

    // R4 R5 masking with mixed routes
    for (int k = 1; k < NS; k++) begin
      bus_wr(AW'(16'h0800 + 8 * k), DW'(k % 8));
      route_sh[k] = 3'(k % 8);
    end
    src = 16'hFFFF;
    mpats = '{16'h0000, 16'hA5A4, 16'hFF00, 16'h00FE};
    foreach (mpats[i]) begin
      bus_wr(16'h0008, DW'(mpats[i][7:0]));
      bus_wr(16'h1008, DW'(mpats[i][15:8]));
      mask_sh = mpats[i] | 16'h0001;
      bus_rd(16'h0010, got); check("R4 R3 masked base word", got, w_base(16'hFFFE & ~mask_sh));
      bus_rd(16'h1010, got); check("R4 masked second word", got, w_second(16'hFFFE & ~mask_sh));
      bus_rd(16'h0008, got); check("R3 mask base word cascade", got, w_base(mask_sh));
      check("R5 outputs under mask", outs(), DW'(exp_out(src)));
    end

    // R7 mailbox group (bits 4..7 in this build)
    bus_wr(16'h0008, '0); bus_wr(16'h1008, '0); mask_sh = 16'h0001;
    bus_wr(16'h0018, 64'h1); mask_sh = 16'h00F1;
    bus_rd(16'h0008, got); check("R7 group set", got, 64'hF0);
    bus_rd(16'h0018, got); check("R7 group read all set", got, 64'h1);
    check("R7 outputs with group masked", outs(), DW'(exp_out(src)));
    bus_wr(16'h0008, 64'h32); mask_sh = 16'h0033;
    bus_rd(16'h0018, got); check("R7 group read partial", got, 64'h0);
    bus_wr(16'h0018, 64'h0); mask_sh = 16'h0003;
    bus_rd(16'h0008, got); check("R7 group clear keeps others", got, 64'h02);

    // R11 unmapped, misaligned and read-only writes
    bus_wr(16'h0020, '1);
    bus_wr(16'h1018, 64'h1);
    bus_wr(16'h0009, '1);
    bus_wr(16'h1800, 64'h7);
    bus_wr(16'h0000, '1);
    bus_wr(16'h0010, '0);
    bus_rd(16'h0008, got); check("R11 mask base unchanged", got, 64'h02);
    bus_rd(16'h1008, got); check("R11 mask second unchanged", got, 64'h00);
    bus_rd(16'h0800, got); check("R11 route 0 unchanged", got, 64'h0);
    bus_rd(16'h0000, got); check("R11 raw ignores write", got, w_base(16'hFFFE));
    bus_rd(16'h0020, got); check("R11 unmapped read", got, '0);
    bus_rd(16'h1018, got); check("R11 group alias in second word", got, '0);
    bus_rd(16'h1800, got); check("R11 route window in second word", got, '0);
    bus_rd(16'h0880, got); check("R11 past route window", got, '0);
    bus_rd(16'h0009, got); check("R11 misaligned read", got, '0);
    check("R5 outputs after ignored writes", outs(), DW'(exp_out(src)));

    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule